// File: doc/BRIEF.md
# Color Lookup Memory with Backdrop Aliasing

This block holds the color table of a tile-based video generator. Thirty-two table slots, selected by a 5-bit index, each hold a 6-bit color code. Two agents use it. The processor side reads and writes slots through a request port. The render side looks up a color every dot through a separate combinational read port.

The backdrop slot of each of the four sprite groups is not separate storage. Indices 0x10, 0x14, 0x18 and 0x1C resolve to the same storage as 0x00, 0x04, 0x08 and 0x0C. As a result, 28 physical words serve all 32 indices.

A processor request is signalled in the dot in which its bus cycle finishes. The request is held for one dot and carried out at the end of the following dot. Write data is committed at that edge. Read data is registered at that edge and flagged valid for one dot.

Top module: `color_table`

## Requirements
- R1: The table has 32 slots, addressed by the 5-bit indices `cpu_idx` and `rnd_idx`. Both ports use the same index-to-slot mapping.
- R2: A write keeps only `cpu_wdata[5:0]`. A write of 0xFF reads back as 0x3F, and `cpu_rdata[7:6]` is always 0.
- R3: Indices 0x10, 0x14, 0x18 and 0x1C share storage with 0x00, 0x04, 0x08 and 0x0C respectively. A write through either index of a pair is visible through both. Writing 0x00..0x1F in ascending order reads back 0x10 at index 0, 0x14 at 4, 0x18 at 8 and 0x1C at 12.
- R4: Every other index has independent storage. A write to one index leaves the value at every non-aliased index unchanged.
- R5: A write request sampled high on `cpu_req` at clock edge N is committed at edge N+1. It is first seen on `rnd_color` in the dot after edge N+1.
- R6: A read request sampled at edge N sets `cpu_rvalid` high, with the slot value on `cpu_rdata`, for exactly the dot after edge N+1. Otherwise `cpu_rvalid` is low.
- R7: `rnd_color` follows `rnd_idx` combinationally. In the dot in which a write is being committed, `rnd_color` still shows the old value of that slot.
- R8: While `rst_n` is low, and directly after reset, `cpu_rvalid` is 0 and `cpu_rdata` is 0. Any pending request is dropped. Table contents are undefined after reset.
- R9: Requests may arrive in consecutive dots. Each one is carried out, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor bus cycle finishes this dot |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | 5 | Processor slot index |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Registered read data, upper two bits zero |
| cpu_rvalid | output | 1 | Read data valid for one dot |
| rnd_idx | input | 5 | Render lookup index |
| rnd_color | output | 6 | Render lookup color |

## Verification
The checker assumes that `cpu_we`, `cpu_idx` and `cpu_wdata` are known whenever `cpu_req` is high. It also assumes that `rnd_idx` is known at each sampling edge. The aliasing properties only compare the render port against data committed in the previous dot. For that reason, the bench drives all inputs on the falling edge and holds them through the following rising edge. Because the contents start undefined, the bench fills every slot before it compares any read.

// File: rtl/color_pkg.sv
package color_pkg;
    parameter int IDX_W   = 5;
    parameter int COLOR_W = 6;
    parameter int BUS_W   = 8;
    parameter int GROUPS  = 4;
    localparam int SLOTS  = 1 << IDX_W;
    localparam int HALF   = SLOTS / 2;
    localparam int STRIDE = HALF / GROUPS;
    localparam int PHYS   = SLOTS - GROUPS;
    localparam int PHYS_W = $clog2(PHYS);

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [COLOR_W-1:0] color_t;
    typedef logic [PHYS_W-1:0]  paddr_t;

    typedef struct packed {
        logic   pend_vld;
        logic   pend_we;
        idx_t   pend_idx;
        color_t pend_wdata;
        logic   rvalid;
        color_t rdata;
    } state_t;

    // Lower half maps 1:1; upper-half backdrops fold onto lower half;
    // remaining upper-half slots are packed after the lower half.
    function automatic paddr_t phys_of(idx_t idx);
        int j;
        j = int'(idx) % HALF;
        if (idx < idx_t'(HALF) || (j % STRIDE) == 0)
            return paddr_t'(j);
        return paddr_t'(HALF + j - (j / STRIDE) - 1);
    endfunction
endpackage

// File: rtl/color_idx_map.sv
module color_idx_map
    import color_pkg::*;
(
    input  idx_t   idx,
    output paddr_t paddr
);
    assign paddr = phys_of(idx);
endmodule

// File: rtl/color_store.sv
module color_store #(
    parameter int DEPTH = 28,
    parameter int W     = 6,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [W-1:0]        wdata,
    input  logic [NRD*AW-1:0]   raddr,
    output logic [NRD*W-1:0]    rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p*W +: W] = mem_q[raddr[p*AW +: AW]];
    end
endmodule

// File: rtl/color_table.sv
module color_table
    import color_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [BUS_W-1:0] cpu_wdata,
    output logic [BUS_W-1:0] cpu_rdata,
    output logic             cpu_rvalid,
    input  logic [IDX_W-1:0] rnd_idx,
    output logic [COLOR_W-1:0] rnd_color
);
    state_t st_d, st_q;
    paddr_t rnd_pa, acc_pa;
    logic [2*COLOR_W-1:0] rd_bus;
    logic                 wr_en;

    // Signals exposed to the bound checker
    logic   pend_vld, pend_we;
    idx_t   pend_idx;
    color_t pend_wdata;

    color_idx_map u_map_rnd (.idx(rnd_idx),     .paddr(rnd_pa));
    color_idx_map u_map_acc (.idx(st_q.pend_idx), .paddr(acc_pa));

    assign wr_en = st_q.pend_vld && st_q.pend_we;

    color_store #(.DEPTH(PHYS), .W(COLOR_W), .NRD(2)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (acc_pa),
        .wdata (st_q.pend_wdata),
        .raddr ({acc_pa, rnd_pa}),
        .rdata (rd_bus)
    );

    always_comb begin
        st_d            = st_q;
        st_d.pend_vld   = cpu_req;
        if (cpu_req) begin
            st_d.pend_we    = cpu_we;
            st_d.pend_idx   = cpu_idx;
            st_d.pend_wdata = cpu_wdata[COLOR_W-1:0];
        end
        st_d.rvalid = st_q.pend_vld && !st_q.pend_we;
        if (st_q.pend_vld && !st_q.pend_we)
            st_d.rdata = rd_bus[COLOR_W +: COLOR_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rnd_color  = rd_bus[0 +: COLOR_W];
    assign cpu_rvalid = st_q.rvalid;
    assign cpu_rdata  = {{(BUS_W-COLOR_W){1'b0}}, st_q.rdata};

    assign pend_vld   = st_q.pend_vld;
    assign pend_we    = st_q.pend_we;
    assign pend_idx   = st_q.pend_idx;
    assign pend_wdata = st_q.pend_wdata;
endmodule

// File: rtl/color_table_chk.sv
module color_table_chk
    import color_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         cpu_req,
    input logic         cpu_we,
    input logic [BUS_W-1:0] cpu_rdata,
    input logic         cpu_rvalid,
    input idx_t         rnd_idx,
    input color_t       rnd_color,
    input logic         pend_vld,
    input logic         pend_we,
    input idx_t         pend_idx,
    input color_t       pend_wdata
);
    localparam idx_t HALF_BIT = idx_t'(HALF);

    // R6: a read request yields valid data two edges later
    a_r6_read_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we) |=> ##1 cpu_rvalid);

    // R6: valid only follows a read request
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(pend_vld && !pend_we));

    // R2: upper read bits are always zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[BUS_W-1:COLOR_W] == '0);

    // R5: committed write visible on the render port at the same index
    a_r5_commit_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld && pend_we) |=>
            (rnd_idx != $past(pend_idx)) || (rnd_color == $past(pend_wdata)));

    // R3: committed backdrop write visible through its alias
    a_r3_alias_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld && pend_we && (int'(pend_idx) % STRIDE == 0)) |=>
            (rnd_idx != ($past(pend_idx) ^ HALF_BIT)) || (rnd_color == $past(pend_wdata)));

    // R8: no read valid straight out of reset
    a_r8_reset_idle: assert property (@(posedge clk)
        !$past(rst_n) |-> !cpu_rvalid);
endmodule

bind color_table color_table_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_rdata  (cpu_rdata),
    .cpu_rvalid (cpu_rvalid),
    .rnd_idx    (rnd_idx),
    .rnd_color  (rnd_color),
    .pend_vld   (pend_vld),
    .pend_we    (pend_we),
    .pend_idx   (pend_idx),
    .pend_wdata (pend_wdata)
);

// File: tb/color_table_tb.sv
module color_table_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [4:0] cpu_idx = '0, rnd_idx = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_rvalid;
    logic [5:0] rnd_color;

    int n_chk = 0, n_bad = 0;
    logic [5:0] shadow [32];

    always #4 clk = ~clk;

    color_table u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .rnd_idx(rnd_idx), .rnd_color(rnd_color)
    );

    function automatic int home(int i);
        return (i % 4 == 0) ? (i % 16) : i;
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(int i, int d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_idx = 5'(i); cpu_wdata = 8'(d);
        shadow[home(i)] = 6'(d);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic rd_chk(string tag, int i);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_idx = 5'(i);
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        chk({tag, " rvalid"}, int'(cpu_rvalid), 1);
        chk(tag, int'(cpu_rdata), int'(shadow[home(i)]));
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 32; i++) rd_chk(tag, i);
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            rnd_idx = 5'(i);
            #1;
            chk({tag, " render R1"}, int'(rnd_color), int'(shadow[home(i)]));
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #20;
        chk("R8 reset rvalid", int'(cpu_rvalid), 0);
        chk("R8 reset rdata", int'(cpu_rdata), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle rvalid", int'(cpu_rvalid), 0);

        // R2: all-ones truncates
        for (int i = 0; i < 32; i++) wr(i, 8'hFF);
        sweep("R2 ones");
        for (int i = 0; i < 32; i++) chk("R2 value", int'(shadow[home(i)]), 8'h3F);

        // R3/R4: ascending pattern
        for (int i = 0; i < 32; i++) wr(i, i);
        chk("R3 idx0", int'(shadow[0]), 8'h10);
        sweep("R3 R4 ascending");

        // R3: descending, low alias wins
        for (int i = 31; i >= 0; i--) wr(i, 8'hC0 | (i + 32));
        sweep("R3 descending");

        // R2/R4: scrambled with high bits set
        for (int i = 0; i < 32; i++) wr((i * 7) % 32, (i * 37 + 5) & 8'hFF);
        sweep("R2 R4 scramble");

        // R5/R7: commit timing against render port
        @(negedge clk);
        rnd_idx = 5'd3;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_idx = 5'd3; cpu_wdata = 8'h2A;
        #1 chk("R7 before capture", int'(rnd_color), int'(shadow[3]));
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R7 commit dot old value", int'(rnd_color), int'(shadow[3]));
        shadow[3] = 6'h2A;
        @(negedge clk);
        chk("R5 visible after commit", int'(rnd_color), 8'h2A);

        // R6: rvalid pulse width
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_idx = 5'd3;
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R6 not yet valid", int'(cpu_rvalid), 0);
        @(negedge clk);
        chk("R6 valid", int'(cpu_rvalid), 1);
        chk("R6 data", int'(cpu_rdata), 8'h2A);
        @(negedge clk);
        chk("R6 single pulse", int'(cpu_rvalid), 0);

        // R9: back-to-back writes then back-to-back reads
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_idx = 5'd5; cpu_wdata = 8'h11;
        @(negedge clk);
        cpu_idx = 5'h1C; cpu_wdata = 8'h22;
        @(negedge clk);
        cpu_idx = 5'd6; cpu_wdata = 8'h33;
        shadow[5] = 6'h11; shadow[12] = 6'h22; shadow[6] = 6'h33;
        @(negedge clk);
        cpu_we = 1'b0; cpu_idx = 5'd5;
        @(negedge clk);
        cpu_idx = 5'd12;
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R9 first read", int'(cpu_rdata), 8'h11);
        @(negedge clk);
        chk("R9 alias read R3", int'(cpu_rdata), 8'h22);
        chk("R9 rvalid", int'(cpu_rvalid), 1);
        rd_chk("R9 third write", 6);

        // R8: reset drops a pending read
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_idx = 5'd6;
        @(negedge clk);
        cpu_req = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 pending dropped", int'(cpu_rvalid), 0);
        chk("R8 rdata cleared", int'(cpu_rdata), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule